// File: doc/BRIEF.md
# Processor Bus Virtual Port Bridge

This block connects a simple asynchronous processor bus to a bank of fifteen 32-bit output registers ("write ports") and fifteen 32-bit input words ("read ports") inside the fabric. The processor selects a port by placing its number on an 8-bit address bus and strobing with active-low chip select plus either an active-low read or an active-low write strobe. A write loads the addressed output register. A read returns the addressed input word on a dedicated read-data output, qualified by an output-enable signal, without using a tri-state bus.

The bus strobes are brought into the master clock domain through a two-flop synchronizer. Each access then produces single-cycle activity flags: a global write pulse, a global read pulse and a per-port select pulse. Fabric logic that treats a port as one atomic word can combine the select bit with the read or write flag to learn exactly which port was touched and in which direction. Address and write data are assumed stable from the strobe's assertion until it is released, and chip select is assumed to assert no later than the strobe.

Top module: `vport_bridge`

## Requirements
- R1: Port k (k = 0..14) lives at bus address k; a write access to address k loads all 32 bits of the bus write data into output port k and leaves every other output port unchanged.
- R2: An output port keeps its value until the next write access to that same port.
- R3: Each write access gives exactly one act_write pulse, one master clock cycle wide, first visible after the third rising clock edge following the strobe assertion; the port register updates in that same cycle.
- R4: Each read access gives exactly one act_read pulse, one cycle wide, with the same three-edge latency as R3.
- R5: During the act_write or act_read pulse, bit k of act_sel (bit 0 = port 0) is high for the accessed port k and all other bits are low; act_sel is zero whenever neither flag is high.
- R6: While chip select and read strobe are both low and the address is 0..14, bus_rdata equals the addressed read port and bus_rdata_oe is 1, with no clock delay.
- R7: Whenever chip select or read strobe is high, bus_rdata_oe is 0 and bus_rdata is zero.
- R8: Accesses at addresses 15 to 255 change no port and raise no activity flag; a read there returns zero with bus_rdata_oe high.
- R9: A read or write strobe asserted while chip select is high has no effect: no port changes, no flag pulses.
- R10: Under reset (rst_n low at a clock edge) all output ports become zero and all activity flags become low.
- R11: A strobe held low for many cycles still produces only one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_addr | input | 8 | Port address |
| bus_wdata | input | 32 | Write data from processor |
| bus_rdata | output | 32 | Read data to processor, zero when not enabled |
| bus_rdata_oe | output | 1 | Read data enable |
| rd_ports | input | 480 | Fifteen read ports, port k at bits 32k+31..32k |
| wr_ports | output | 480 | Fifteen write ports, port k at bits 32k+31..32k |
| act_read | output | 1 | One-cycle read activity pulse |
| act_write | output | 1 | One-cycle write activity pulse |
| act_sel | output | 15 | One-cycle per-port activity pulse |

## Verification
The bench targets the first and last port numbers and the first illegal address, where an off-by-one decoder would either lose port 14 or write a phantom port 15 and pulse flags. Strobes held for twenty cycles expose level-based detection, which would emit a pulse each cycle instead of one. Strobes without chip select and reads with the strobe released check the gating; a design that ignores the select would write ports and pulse flags, and one that lets data leak would show nonzero read data with the enable low. Back-to-back writes to neighbouring ports confirm that a load does not spill into, or clear, another port's register.

// File: rtl/vport_pkg.sv
// Shared constants and types for the virtual port bridge.
package vport_pkg;
    localparam int VP_PORTS  = 15;
    localparam int VP_DATA_W = 32;
    localparam int VP_ADDR_W = 8;

    // Bus control lines in active-high form, one bit each.
    typedef struct packed {
        logic cs;
        logic rd;
        logic wr;
    } bus_ctl_t;
endpackage

// File: rtl/vport_sync.sv
// Multi-stage synchronizer with rising-edge detect.
// Assumes inputs are active high and quasi-static relative to the clock;
// each bit is synchronized independently.
module vport_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_q,
    output logic [W-1:0] rise
);
    logic [W-1:0] pipe [STAGES];
    logic [W-1:0] last;

    // Shift the asynchronous inputs through the flop chain and keep one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
            last <= '0;
        end else begin
            pipe[0] <= async_in;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            last <= pipe[STAGES-1];
        end
    end

    assign sync_q = pipe[STAGES-1];
    assign rise   = sync_q & ~last;
endmodule

// File: rtl/vport_decode.sv
// Address decoder: one-hot port hit for addresses 0..N-1, nothing above.
// Assumes N <= 2**AW.
module vport_decode #(
    parameter int N  = 15,
    parameter int AW = 8
) (
    input  logic [AW-1:0] addr,
    output logic [N-1:0]  hit,
    output logic          valid
);
    for (genvar k = 0; k < N; k++) begin : g_cmp
        // Compare against this port's fixed address.
        assign hit[k] = (addr == AW'(k));
    end
    assign valid = |hit;
endmodule

// File: rtl/vport_wr_bank.sv
// Bank of N write-port registers; each loads bus data when its load bit is set.
// Assumes load is at most one-hot.
module vport_wr_bank #(
    parameter int N  = 15,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  load,
    input  logic [DW-1:0] din,
    output logic [N*DW-1:0] q
);
    for (genvar k = 0; k < N; k++) begin : g_port
        logic [DW-1:0] r;

        // Hold the port value; replace it only on a load for this port.
        always_ff @(posedge clk) begin
            if (!rst_n)       r <= '0;
            else if (load[k]) r <= din;
        end

        assign q[k*DW +: DW] = r;

        assert_port_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !load[k] |=> $stable(q[k*DW +: DW]));
    end
endmodule

// File: rtl/vport_rd_mux.sv
// Read-port selector: AND-OR mux over a one-hot select, gated by an enable.
// Output is zero when disabled or when no select bit is set.
module vport_rd_mux #(
    parameter int N  = 15,
    parameter int DW = 32
) (
    input  logic [N*DW-1:0] ports_in,
    input  logic [N-1:0]    sel,
    input  logic            en,
    output logic [DW-1:0]   dout
);
    logic [DW-1:0] acc;

    // Combine the selected port into one word.
    always_comb begin
        acc = '0;
        for (int k = 0; k < N; k++) begin
            if (sel[k]) acc = acc | ports_in[k*DW +: DW];
        end
    end

    assign dout = en ? acc : '0;
endmodule

// File: rtl/vport_bridge.sv
// Processor bus to virtual port bridge.
// Assumes address and write data are stable while the strobe is low, and
// chip select asserts no later than the strobe. All flags are in clk domain.
module vport_bridge
    import vport_pkg::*;
#(
    parameter int NUM_PORTS   = VP_PORTS,
    parameter int DATA_W      = VP_DATA_W,
    parameter int ADDR_W      = VP_ADDR_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_cs_n,
    input  logic                        bus_rd_n,
    input  logic                        bus_wr_n,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    output logic                        bus_rdata_oe,
    input  logic [NUM_PORTS*DATA_W-1:0] rd_ports,
    output logic [NUM_PORTS*DATA_W-1:0] wr_ports,
    output logic                        act_read,
    output logic                        act_write,
    output logic [NUM_PORTS-1:0]        act_sel
);
    localparam int CTL_W = $bits(bus_ctl_t);

    bus_ctl_t             ctl_async, ctl_sync, ctl_rise;
    logic [NUM_PORTS-1:0] port_hit;
    logic                 addr_ok;
    logic                 wr_evt, rd_evt;
    logic [NUM_PORTS-1:0] wr_load;

    assign ctl_async = '{cs: ~bus_cs_n, rd: ~bus_rd_n, wr: ~bus_wr_n};

    vport_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ctl_async),
        .sync_q   (ctl_sync),
        .rise     (ctl_rise)
    );

    vport_decode #(.N(NUM_PORTS), .AW(ADDR_W)) u_dec (
        .addr  (bus_addr),
        .hit   (port_hit),
        .valid (addr_ok)
    );

    // One event per strobe assertion, qualified by select and a legal address.
    assign wr_evt  = ctl_rise.wr & ctl_sync.cs & addr_ok;
    assign rd_evt  = ctl_rise.rd & ctl_sync.cs & addr_ok;
    assign wr_load = wr_evt ? port_hit : '0;

    vport_wr_bank #(.N(NUM_PORTS), .DW(DATA_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (wr_load),
        .din   (bus_wdata),
        .q     (wr_ports)
    );

    assign bus_rdata_oe = ~bus_cs_n & ~bus_rd_n;

    vport_rd_mux #(.N(NUM_PORTS), .DW(DATA_W)) u_mux (
        .ports_in (rd_ports),
        .sel      (port_hit),
        .en       (bus_rdata_oe),
        .dout     (bus_rdata)
    );

    // Register the activity flags so they align with the port register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_write <= 1'b0;
            act_read  <= 1'b0;
            act_sel   <= '0;
        end else begin
            act_write <= wr_evt;
            act_read  <= rd_evt;
            act_sel   <= (wr_evt | rd_evt) ? port_hit : '0;
        end
    end

    assert_write_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        act_write |=> !act_write);
    assert_read_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        act_read |=> !act_read);
    assert_sel_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(act_sel));
    assert_sel_needs_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|act_sel) |-> (act_read | act_write));
    assert_flag_has_port_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (act_read | act_write) |-> $countones(act_sel) == 1);
    assert_idle_data_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rdata_oe |-> bus_rdata == '0);
endmodule

// File: tb/sim_vport_bridge.sv
module sim_vport_bridge;
    localparam int NP = 15;
    localparam int DW = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_cs_n = 1'b1, bus_rd_n = 1'b1, bus_wr_n = 1'b1;
    logic [7:0]        bus_addr = '0;
    logic [DW-1:0]     bus_wdata = '0;
    logic [DW-1:0]     bus_rdata;
    logic              bus_rdata_oe;
    logic [NP*DW-1:0]  rd_ports;
    logic [NP*DW-1:0]  wr_ports;
    logic              act_read, act_write;
    logic [NP-1:0]     act_sel;

    int tests = 0;
    int fails = 0;
    bit done  = 0;
    logic [DW-1:0] model [NP];

    always #10 clk = ~clk;

    vport_bridge u0 (
        .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
        .bus_wr_n(bus_wr_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rdata_oe(bus_rdata_oe), .rd_ports(rd_ports),
        .wr_ports(wr_ports), .act_read(act_read), .act_write(act_write),
        .act_sel(act_sel)
    );

    function automatic logic [DW-1:0] rpat(input int k);
        return {8'hC0 + 8'(k), 8'(k), 8'hA5, ~8'(k)};
    endfunction

    for (genvar k = 0; k < NP; k++) begin : g_rd
        assign rd_ports[k*DW +: DW] = rpat(k);
    end

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_ports(input string req);
        bit ok = 1;
        logic [DW-1:0] a = '0, e = '0;
        for (int k = 0; k < NP; k++) begin
            if (wr_ports[k*DW +: DW] !== model[k] && ok) begin
                ok = 0; a = wr_ports[k*DW +: DW]; e = model[k];
            end
        end
        chk(ok, req, a, e);
    endtask

    // Drive one access, hold the strobe for 'hold' cycles, watch flags afterwards.
    task automatic access(input bit is_wr, input logic [7:0] a, input logic [DW-1:0] d,
                          input bit with_cs, input int hold,
                          output int n_w, output int n_r, output int first,
                          output logic [NP-1:0] sel_seen,
                          output logic [DW-1:0] rd_seen, output logic oe_seen);
        n_w = 0; n_r = 0; first = -1; sel_seen = '0;
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_cs_n = !with_cs;
        if (is_wr) bus_wr_n = 1'b0; else bus_rd_n = 1'b0;
        #1;
        rd_seen = bus_rdata; oe_seen = bus_rdata_oe;
        for (int i = 1; i <= hold + 5; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (act_write) n_w++;
            if (act_read) n_r++;
            if ((act_write || act_read) && first < 0) first = i;
            sel_seen = sel_seen | act_sel;
            if (i == hold) begin
                bus_wr_n = 1'b1; bus_rd_n = 1'b1; bus_cs_n = 1'b1;
            end
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [DW-1:0] d, input string req);
        int nw, nr, f; logic [NP-1:0] s; logic [DW-1:0] r; logic oe;
        access(1, a, d, 1, 4, nw, nr, f, s, r, oe);
        model[a] = d;
        chk(nw == 1 && nr == 0, {req, " R3 one write pulse"}, nw, 1);
        chk(f == 3, {req, " R3 pulse latency"}, f, 3);
        chk(s == (15'd1 << a), {req, " R5 select bit"}, s, 15'd1 << a);
        chk_ports({req, " R1 port contents"});
    endtask

    task automatic t_reset;
        chk(wr_ports == '0, "R10 ports zero after reset", wr_ports[DW-1:0], 0);
        chk(!act_read && !act_write && act_sel == '0, "R10 flags low after reset",
            {act_read, act_write, act_sel}, 0);
        chk(!bus_rdata_oe && bus_rdata == '0, "R7 idle read data", bus_rdata, 0);
    endtask

    task automatic t_write_basic;
        do_write(8'd3, 32'hDEADBEEF, "R1 port3");
        do_write(8'd0, 32'hFFFFFFFF, "R1 port0");
        do_write(8'd14, 32'h00000001, "R1 port14");
    endtask

    task automatic t_hold;
        do_write(8'd5, 32'h12345678, "R2 port5");
        do_write(8'd6, 32'h87654321, "R2 port6");
        chk(wr_ports[5*DW +: DW] == 32'h12345678, "R2 port5 kept", wr_ports[5*DW +: DW],
            32'h12345678);
        do_write(8'd5, 32'h0F0F0F0F, "R2 port5 rewrite");
    endtask

    task automatic t_read(input int k);
        int nw, nr, f; logic [NP-1:0] s; logic [DW-1:0] r; logic oe;
        access(0, 8'(k), '0, 1, 4, nw, nr, f, s, r, oe);
        chk(r == rpat(k) && oe, "R6 read data", r, rpat(k));
        chk(nr == 1 && nw == 0, "R4 one read pulse", nr, 1);
        chk(f == 3, "R4 read latency", f, 3);
        chk(s == (15'd1 << k), "R5 read select bit", s, 15'd1 << k);
        chk_ports("R4 read leaves ports");
    endtask

    task automatic t_no_cs;
        int nw, nr, f; logic [NP-1:0] s; logic [DW-1:0] r; logic oe;
        access(0, 8'd2, '0, 0, 4, nw, nr, f, s, r, oe);
        chk(r == '0 && !oe, "R7 read without select", r, 0);
        chk(nr == 0 && s == '0, "R9 no read pulse without select", nr, 0);
        access(1, 8'd2, 32'hCAFEF00D, 0, 4, nw, nr, f, s, r, oe);
        chk(nw == 0 && s == '0, "R9 no write pulse without select", nw, 0);
        chk_ports("R9 write without select ignored");
    endtask

    task automatic t_out_of_range;
        int nw, nr, f; logic [NP-1:0] s; logic [DW-1:0] r; logic oe;
        access(1, 8'd15, 32'hBADBAD01, 1, 4, nw, nr, f, s, r, oe);
        chk(nw == 0 && s == '0, "R8 addr15 no pulse", nw, 0);
        chk_ports("R8 addr15 no write");
        access(1, 8'd200, 32'hBADBAD02, 1, 4, nw, nr, f, s, r, oe);
        chk(nw == 0 && s == '0, "R8 addr200 no pulse", nw, 0);
        chk_ports("R8 addr200 no write");
        access(0, 8'd255, '0, 1, 4, nw, nr, f, s, r, oe);
        chk(r == '0 && oe, "R8 addr255 reads zero", r, 0);
        chk(nr == 0 && s == '0, "R8 addr255 no read pulse", nr, 0);
    endtask

    task automatic t_long;
        int nw, nr, f; logic [NP-1:0] s; logic [DW-1:0] r; logic oe;
        access(1, 8'd9, 32'h5A5A5A5A, 1, 20, nw, nr, f, s, r, oe);
        model[9] = 32'h5A5A5A5A;
        chk(nw == 1, "R11 long write one pulse", nw, 1);
        chk_ports("R11 long write data");
        access(0, 8'd11, '0, 1, 20, nw, nr, f, s, r, oe);
        chk(nr == 1, "R11 long read one pulse", nr, 1);
    endtask

    initial begin
        for (int k = 0; k < NP; k++) model[k] = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_write_basic;
        t_hold;
        t_read(7);
        t_read(0);
        t_read(14);
        t_no_cs;
        t_out_of_range;
        t_long;
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog R1..: run did not finish, actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule